// File: doc/BRIEF.md
# Interruption Address Shadow Queues

The block keeps a shadow copy of the two-entry live instruction address queue, front and back, split into a space part and an offset part. While the collection enable bit is 1, both shadow queues follow the live queue on every cycle. When an interruption clears the enable bit, the last captured point of interruption stays frozen. In the offset entries, the two least significant bits hold the privilege level.

While the shadows are frozen, handler software reaches them through control-register style ports. A read returns the front entry. A write first shifts the back entry into the front slot and then loads the written value into the back slot. This lets a handler rebuild a full two-entry return point with two writes. On return from interruption the block presents the offsets unchanged. It also presents space values rebuilt from the captured spaces by clearing every low space bit whose matching offset bit is set. A single-cycle load strobe marks the return.

Top module: `iaq_shadow`

## Requirements
- R1: After synchronous reset, all four shadow entries are zero, so both read ports and all four return outputs are zero.
- R2: While `q_en_i` is 1, each clock edge copies the live front and back space and offset values into the shadow entries. When `q_en_i` is 0, the entries keep their last captured values.
- R3: A capture made while `code_xlate_i` is 0 stores zero in both space entries.
- R4: A capture made while `code_xlate_i` is 0 and `wide_i` is 0 keeps only offset bits 31:0 (LSB numbering) and stores zero in all higher offset bits. In every other case the full offset is captured.
- R5: While `q_en_i` is 0, `sq_rdata_o` and `oq_rdata_o` show the front entry of their queue. While `q_en_i` is 1, both show zero.
- R6: With `q_en_i` 0 and `intr_i` 0, a write strobe moves that queue's back entry to its front and loads the write data into its back, both at the same edge. The other queue is unaffected.
- R7: A write strobe while `q_en_i` is 1 has no effect: after `q_en_i` falls, the queues hold the last live values, not the written data.
- R8: An interruption strobe while `q_en_i` is 0 leaves all four entries unchanged, even when a write strobe arrives in the same cycle.
- R9: `rest_load_o` is 1 exactly in cycles where `rfi_i` is 1 and `q_en_i` is 0. The return offset outputs always equal the shadow offset entries.
- R10: Each return space output (LSB numbering, 64-bit default) keeps bits 63:30 of its shadow space entry. Its bits 29:0 equal shadow space bits 29:0 ANDed with the complement of the matching offset entry bits 61:32.
- R11: A return strobe while `q_en_i` is 1 leaves `rest_load_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_en_i | input | 1 | Collection enable bit |
| intr_i | input | 1 | Interruption strobe |
| code_xlate_i | input | 1 | Code address translation enabled |
| wide_i | input | 1 | Wide addressing mode |
| live_sp_front_i | input | SPACE_W | Live front space value |
| live_sp_back_i | input | SPACE_W | Live back space value |
| live_off_front_i | input | OFFS_W | Live front offset with privilege level |
| live_off_back_i | input | OFFS_W | Live back offset with privilege level |
| sq_wr_i | input | 1 | Space queue write strobe |
| sq_wdata_i | input | SPACE_W | Space queue write data |
| oq_wr_i | input | 1 | Offset queue write strobe |
| oq_wdata_i | input | OFFS_W | Offset queue write data |
| sq_rdata_o | output | SPACE_W | Space queue read data |
| oq_rdata_o | output | OFFS_W | Offset queue read data |
| rfi_i | input | 1 | Return-from-interruption strobe |
| rest_load_o | output | 1 | Load strobe for the live queue |
| rest_sp_front_o | output | SPACE_W | Rebuilt front space |
| rest_sp_back_o | output | SPACE_W | Rebuilt back space |
| rest_off_front_o | output | OFFS_W | Restored front offset |
| rest_off_back_o | output | OFFS_W | Restored back offset |

## Verification
The bench builds the block at the default 64-bit space and 64-bit offset widths. At these widths the masking window for the rebuilt space sits at offset bits 61:32 and the narrow truncation boundary sits at bit 32. Table vectors place set bits inside, outside and on the edges of both regions. Directed sequences then cover the shift-then-load order over two successive writes, writes and return strobes made while collection is enabled, and an interruption that collides with a write.

// File: rtl/iaq_pkg.sv
package iaq_pkg;

    // Number of low space bits that the return path clears using offset bits
    localparam int MASK_BITS = 30;
    // Privilege level field width at the bottom of each offset entry
    localparam int PRIV_BITS = 2;
    // Offset bits kept in a narrow, untranslated capture
    localparam int NARROW_OFF_W = 32;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_TRACK = 2'd1,
        OP_PUSH  = 2'd2
    } q_op_e;

    // Interruption with collection off freezes everything, including a CR write
    function automatic q_op_e pick_op(input logic q_en, input logic intr, input logic wr);
        if (q_en)
            return OP_TRACK;
        else if (intr)
            return OP_HOLD;
        else if (wr)
            return OP_PUSH;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/iaq_pair.sv
module iaq_pair
    import iaq_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  q_op_e        op_i,
    input  logic [W-1:0] cap_front_i,
    input  logic [W-1:0] cap_back_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] front_o,
    output logic [W-1:0] back_o
);

    logic [W-1:0] front_q, back_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            front_q <= '0;
            back_q  <= '0;
        end else begin
            unique case (op_i)
                OP_TRACK: begin
                    front_q <= cap_front_i;
                    back_q  <= cap_back_i;
                end
                OP_PUSH: begin
                    front_q <= back_q;
                    back_q  <= wdata_i;
                end
                default: ;
            endcase
        end
    end

    assign front_o = front_q;
    assign back_o  = back_q;

    // Shift happens before the load: old back reaches the front
    assert_push_order_R6: assert property (@(posedge clk) disable iff (rst)
        (!rst && op_i == OP_PUSH) |=> (front_o == $past(back_o) && back_o == $past(wdata_i)));

    assert_hold_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (!rst && op_i == OP_HOLD) |=> ($stable(front_o) && $stable(back_o)));

    assert_track_copy_R2: assert property (@(posedge clk) disable iff (rst)
        (!rst && op_i == OP_TRACK) |=> (front_o == $past(cap_front_i) && back_o == $past(cap_back_i)));

endmodule

// File: rtl/iaq_reform.sv
module iaq_reform
    import iaq_pkg::*;
#(
    parameter int SPACE_W = 64,
    parameter int OFFS_W  = 64,
    parameter int N_ENT   = 2
) (
    input  logic [SPACE_W-1:0] sp_i   [N_ENT],
    input  logic [OFFS_W-1:0]  off_i  [N_ENT],
    output logic [SPACE_W-1:0] sp_o   [N_ENT],
    output logic [OFFS_W-1:0]  off_o  [N_ENT]
);

    // Mask window starts just below the two top offset bits
    localparam int MASK_TOP = OFFS_W - 1 - PRIV_BITS;

    for (genvar k = 0; k < N_ENT; k++) begin : g_ent
        logic [MASK_BITS-1:0] mask_bits;
        assign mask_bits = off_i[k][MASK_TOP -: MASK_BITS];
        assign sp_o[k]   = {sp_i[k][SPACE_W-1:MASK_BITS],
                            sp_i[k][MASK_BITS-1:0] & ~mask_bits};
        assign off_o[k]  = off_i[k];
    end

endmodule

// File: rtl/iaq_shadow.sv
module iaq_shadow
    import iaq_pkg::*;
#(
    parameter int SPACE_W = 64,
    parameter int OFFS_W  = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               q_en_i,
    input  logic               intr_i,
    input  logic               code_xlate_i,
    input  logic               wide_i,
    input  logic [SPACE_W-1:0] live_sp_front_i,
    input  logic [SPACE_W-1:0] live_sp_back_i,
    input  logic [OFFS_W-1:0]  live_off_front_i,
    input  logic [OFFS_W-1:0]  live_off_back_i,
    input  logic               sq_wr_i,
    input  logic [SPACE_W-1:0] sq_wdata_i,
    input  logic               oq_wr_i,
    input  logic [OFFS_W-1:0]  oq_wdata_i,
    output logic [SPACE_W-1:0] sq_rdata_o,
    output logic [OFFS_W-1:0]  oq_rdata_o,
    input  logic               rfi_i,
    output logic               rest_load_o,
    output logic [SPACE_W-1:0] rest_sp_front_o,
    output logic [SPACE_W-1:0] rest_sp_back_o,
    output logic [OFFS_W-1:0]  rest_off_front_o,
    output logic [OFFS_W-1:0]  rest_off_back_o
);

    localparam int N_ENT = 2;
    localparam int MASK_TOP = OFFS_W - 1 - PRIV_BITS;
    localparam logic [OFFS_W-1:0] NARROW_KEEP = ~({OFFS_W{1'b1}} << NARROW_OFF_W);

    q_op_e sq_op, oq_op;
    logic [SPACE_W-1:0] cap_sp_front, cap_sp_back;
    logic [OFFS_W-1:0]  cap_off_front, cap_off_back;
    logic [SPACE_W-1:0] sp_front, sp_back;
    logic [OFFS_W-1:0]  off_front, off_back;
    logic               narrow_abs;

    assign sq_op = pick_op(q_en_i, intr_i, sq_wr_i);
    assign oq_op = pick_op(q_en_i, intr_i, oq_wr_i);

    // Capture shaping: untranslated spaces read as zero, narrow absolute offsets truncated
    assign narrow_abs    = !code_xlate_i && !wide_i;
    assign cap_sp_front  = code_xlate_i ? live_sp_front_i : '0;
    assign cap_sp_back   = code_xlate_i ? live_sp_back_i  : '0;
    assign cap_off_front = narrow_abs ? (live_off_front_i & NARROW_KEEP) : live_off_front_i;
    assign cap_off_back  = narrow_abs ? (live_off_back_i  & NARROW_KEEP) : live_off_back_i;

    iaq_pair #(.W(SPACE_W)) i_space_q (
        .clk         (clk),
        .rst         (rst),
        .op_i        (sq_op),
        .cap_front_i (cap_sp_front),
        .cap_back_i  (cap_sp_back),
        .wdata_i     (sq_wdata_i),
        .front_o     (sp_front),
        .back_o      (sp_back)
    );

    iaq_pair #(.W(OFFS_W)) i_offset_q (
        .clk         (clk),
        .rst         (rst),
        .op_i        (oq_op),
        .cap_front_i (cap_off_front),
        .cap_back_i  (cap_off_back),
        .wdata_i     (oq_wdata_i),
        .front_o     (off_front),
        .back_o      (off_back)
    );

    // Read port: front element while frozen, zero while tracking
    assign sq_rdata_o = q_en_i ? '0 : sp_front;
    assign oq_rdata_o = q_en_i ? '0 : off_front;

    logic [SPACE_W-1:0] rf_sp_in  [N_ENT];
    logic [OFFS_W-1:0]  rf_off_in [N_ENT];
    logic [SPACE_W-1:0] rf_sp_out [N_ENT];
    logic [OFFS_W-1:0]  rf_off_out[N_ENT];

    assign rf_sp_in[0]  = sp_front;
    assign rf_sp_in[1]  = sp_back;
    assign rf_off_in[0] = off_front;
    assign rf_off_in[1] = off_back;

    iaq_reform #(.SPACE_W(SPACE_W), .OFFS_W(OFFS_W), .N_ENT(N_ENT)) i_reform (
        .sp_i  (rf_sp_in),
        .off_i (rf_off_in),
        .sp_o  (rf_sp_out),
        .off_o (rf_off_out)
    );

    assign rest_sp_front_o  = rf_sp_out[0];
    assign rest_sp_back_o   = rf_sp_out[1];
    assign rest_off_front_o = rf_off_out[0];
    assign rest_off_back_o  = rf_off_out[1];
    assign rest_load_o      = rfi_i && !q_en_i;

    // Rebuilt low space bits never overlap the offset bits that mask them
    assert_mask_disjoint_R10: assert property (@(posedge clk) disable iff (rst)
        ((rest_sp_front_o[MASK_BITS-1:0] & rest_off_front_o[MASK_TOP -: MASK_BITS]) == '0) &&
        ((rest_sp_back_o[MASK_BITS-1:0]  & rest_off_back_o[MASK_TOP -: MASK_BITS])  == '0));

    // Untranslated capture leaves zero spaces behind
    assert_untranslated_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (!rst && q_en_i && !code_xlate_i) |=> (rest_sp_front_o == '0 && rest_sp_back_o == '0));

    // Interruption with collection off changes nothing visible on the return outputs
    assert_intr_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (!rst && intr_i && !q_en_i) |=> ($stable(rest_off_front_o) && $stable(rest_off_back_o) &&
                                         $stable(rest_sp_front_o) && $stable(rest_sp_back_o)));

    assert_load_gate_R11: assert property (@(posedge clk) disable iff (rst)
        q_en_i |-> !rest_load_o);

endmodule

// File: tb/test_iaq_shadow.sv
module test_iaq_shadow;

    localparam int SW = 64;
    localparam int OW = 64;

    logic          clk = 1'b0;
    logic          rst;
    logic          q_en, intr, xlate, wide;
    logic [SW-1:0] lsf, lsb;
    logic [OW-1:0] lof, lob;
    logic          sq_wr, oq_wr, rfi;
    logic [SW-1:0] sq_wd;
    logic [OW-1:0] oq_wd;
    logic [SW-1:0] sq_rd, r_sf, r_sb;
    logic [OW-1:0] oq_rd, r_of, r_ob;
    logic          r_load;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    iaq_shadow #(.SPACE_W(SW), .OFFS_W(OW)) i_iaq_shadow (
        .clk(clk), .rst(rst), .q_en_i(q_en), .intr_i(intr), .code_xlate_i(xlate), .wide_i(wide),
        .live_sp_front_i(lsf), .live_sp_back_i(lsb), .live_off_front_i(lof), .live_off_back_i(lob),
        .sq_wr_i(sq_wr), .sq_wdata_i(sq_wd), .oq_wr_i(oq_wr), .oq_wdata_i(oq_wd),
        .sq_rdata_o(sq_rd), .oq_rdata_o(oq_rd), .rfi_i(rfi), .rest_load_o(r_load),
        .rest_sp_front_o(r_sf), .rest_sp_back_o(r_sb), .rest_off_front_o(r_of), .rest_off_back_o(r_ob)
    );

    typedef struct packed {
        logic [63:0] sf;
        logic [63:0] of;
        logic [63:0] sb;
        logic [63:0] ob;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0003, 64'hFFFF_FFFF_FFFF_FFFF, 64'h3FFF_FFFF_0000_0000},
        '{64'h1234_5678_9ABC_DEF1, 64'h0000_0001_0000_0002, 64'h0000_0000_3FFF_FFFF, 64'h2000_0000_0000_0001},
        '{64'hDEAD_BEEF_C000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_2AAA_AAAA, 64'h1555_5555_0000_0000},
        '{64'h8000_0000_4000_0001, 64'hC000_0000_0000_0000, 64'h0000_0001_0000_0000, 64'h0000_0000_FFFF_FFFF},
        '{64'h0F0F_0F0F_0F0F_0F0F, 64'h00F0_0F00_0000_0001, 64'hFFFF_0000_0000_FFFF, 64'h0000_FFFF_0000_0000}
    };

    // Rebuild formula from R10: keep bits 63:30, clear bits 29:0 where offset bits 61:32 are set
    function automatic logic [63:0] exp_reform(input logic [63:0] sp, input logic [63:0] off);
        return {sp[63:30], sp[29:0] & ~off[61:32]};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        check(act === exp, tag, act, exp);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic capture(input logic [63:0] sf, input logic [63:0] of,
                           input logic [63:0] sb, input logic [63:0] ob);
        q_en = 1'b1; lsf = sf; lof = of; lsb = sb; lob = ob;
        step();
        q_en = 1'b0;
        settle();
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] back_before, off_front_before;
        rst = 1'b1; q_en = 1'b0; intr = 1'b0; xlate = 1'b1; wide = 1'b1;
        lsf = '0; lsb = '0; lof = '0; lob = '0;
        sq_wr = 1'b0; oq_wr = 1'b0; sq_wd = '0; oq_wd = '0; rfi = 1'b0;
        step(); step();
        rst = 1'b0;
        settle();

        // R1 reset state
        chk("R1 sq_rdata", sq_rd, '0);
        chk("R1 oq_rdata", oq_rd, '0);
        chk("R1 rest_sp_front", r_sf, '0);
        chk("R1 rest_sp_back", r_sb, '0);
        chk("R1 rest_off_back", r_ob, '0);

        // Table walk: capture, freeze, return
        for (int i = 0; i < NV; i++) begin
            capture(VECS[i].sf, VECS[i].of, VECS[i].sb, VECS[i].ob);
            chk("R2 R5 front space read", sq_rd, VECS[i].sf);
            chk("R2 R5 front offset read", oq_rd, VECS[i].of);
            rfi = 1'b1;
            settle();
            chk("R9 load strobe", {63'd0, r_load}, 64'd1);
            chk("R9 front offset restore", r_of, VECS[i].of);
            chk("R9 back offset restore", r_ob, VECS[i].ob);
            chk("R10 front space rebuild", r_sf, exp_reform(VECS[i].sf, VECS[i].of));
            chk("R10 back space rebuild", r_sb, exp_reform(VECS[i].sb, VECS[i].ob));
            rfi = 1'b0;
            step();
            settle();
            chk("R9 load drops", {63'd0, r_load}, 64'd0);
            chk("R2 frozen hold", sq_rd, VECS[i].sf);
        end

        // R3 untranslated, wide: spaces zero, offsets full
        xlate = 1'b0; wide = 1'b1;
        capture(64'hAAAA_5555_1234_5678, 64'hFEDC_BA98_7654_3210, 64'h1111_2222_3333_4444, 64'h8000_0001_0000_0003);
        chk("R3 front space zero", sq_rd, '0);
        chk("R3 back space zero", r_sb, '0);
        chk("R4 wide keeps full offset", oq_rd, 64'hFEDC_BA98_7654_3210);

        // R4 untranslated, narrow: offsets truncated to 32 bits
        wide = 1'b0;
        capture(64'h1, 64'hFEDC_BA98_7654_3210, 64'h2, 64'h8000_0001_0000_0003);
        chk("R4 narrow front offset", oq_rd, 64'h0000_0000_7654_3210);
        chk("R4 narrow back offset", r_ob, 64'h0000_0000_0000_0003);

        // R4 translated and narrow: full offset
        xlate = 1'b1;
        capture(64'h0000_00AB_0000_0000, 64'hFEDC_BA98_7654_3210, 64'h0000_00CD_0000_0000, 64'h7777_0000_0000_0004);
        chk("R4 translated narrow offset", oq_rd, 64'hFEDC_BA98_7654_3210);
        chk("R2 space capture", sq_rd, 64'h0000_00AB_0000_0000);
        wide = 1'b1;

        // R6 two writes to space queue: shift then load
        back_before = 64'h0000_00CD_0000_0000;
        off_front_before = 64'hFEDC_BA98_7654_3210;
        sq_wr = 1'b1; sq_wd = 64'h1111_1111_1111_1111;
        step();
        sq_wd = 64'h2222_2222_2222_2222;
        settle();
        chk("R6 first write front", sq_rd, back_before);
        chk("R6 first write back", r_sb, exp_reform(64'h1111_1111_1111_1111, 64'h7777_0000_0000_0004));
        chk("R6 offset queue untouched", oq_rd, off_front_before);
        step();
        sq_wr = 1'b0;
        settle();
        chk("R6 second write front", sq_rd, 64'h1111_1111_1111_1111);

        // R6 offset queue write
        oq_wr = 1'b1; oq_wd = 64'h0000_0000_0000_0ABC;
        step();
        oq_wr = 1'b0;
        settle();
        chk("R6 offset write front", oq_rd, 64'h7777_0000_0000_0004);
        chk("R6 offset write back", r_ob, 64'h0000_0000_0000_0ABC);
        chk("R6 space queue untouched", sq_rd, 64'h1111_1111_1111_1111);

        // R8 interruption with Q=0 plus a colliding write
        intr = 1'b1; sq_wr = 1'b1; oq_wr = 1'b1;
        sq_wd = 64'h3333_3333_3333_3333; oq_wd = 64'h4444_4444_4444_4444;
        step();
        intr = 1'b0; sq_wr = 1'b0; oq_wr = 1'b0;
        settle();
        chk("R8 space front frozen", sq_rd, 64'h1111_1111_1111_1111);
        chk("R8 offset front frozen", oq_rd, 64'h7777_0000_0000_0004);
        chk("R8 offset back frozen", r_ob, 64'h0000_0000_0000_0ABC);

        // R5 reads zero while Q=1; R11 no load strobe; R7 write ignored
        q_en = 1'b1; lsf = 64'h5A5A_0000_0000_0000; lof = 64'h0000_0000_0000_0010;
        lsb = 64'h0000_5A5A_0000_0000; lob = 64'h0000_0000_0000_0020;
        rfi = 1'b1; sq_wr = 1'b1; oq_wr = 1'b1;
        sq_wd = 64'hBAD0_BAD0_BAD0_BAD0; oq_wd = 64'hBAD1_BAD1_BAD1_BAD1;
        settle();
        chk("R5 space read zero while tracking", sq_rd, '0);
        chk("R5 offset read zero while tracking", oq_rd, '0);
        chk("R11 no load while tracking", {63'd0, r_load}, 64'd0);
        step();
        q_en = 1'b0; rfi = 1'b0; sq_wr = 1'b0; oq_wr = 1'b0;
        settle();
        chk("R7 space write ignored", sq_rd, 64'h5A5A_0000_0000_0000);
        chk("R7 offset write ignored", oq_rd, 64'h0000_0000_0000_0010);
        chk("R7 back offset live", r_ob, 64'h0000_0000_0000_0020);

        // R1 reset clears written state
        rst = 1'b1;
        step();
        rst = 1'b0;
        settle();
        chk("R1 reset after use", sq_rd, '0);
        chk("R1 reset offset after use", r_ob, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule